// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Slave Front End

This block is the serial front end of a small 128-byte non-volatile store. It watches already-synchronized samples of the two-wire bus clock and data lines and runs on a fast system clock. It recognises bus start and stop conditions and answers only the fixed device code 1010000. In a write transaction, the first byte after the control byte sets an internal word pointer. Each data byte after that goes out on a one-cycle strobe to a page-write buffer, together with its target address. When the bus master ends the write with a stop condition, a commit pulse starts the self-timed programming cycle.

In a read transaction the block fetches bytes from a combinational memory read port addressed by the pointer. It shifts them out most significant bit first and keeps reading sequentially for as long as the master acknowledges. The block drives the data line only through an open-drain pull-down enable. Every change of that enable waits a fixed number of system clocks after the bus clock falls, so the slave never creates a false start or stop. A busy input from the write-cycle controller makes the slave silent on every byte while programming runs.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the pull-down enable is released, no write strobe or commit pulse is issued, and the word pointer (seen on the read address port) is 0.
- R2: Data falling while the bus clock is high is a start and restarts control-byte decoding, also mid-byte (a repeated start aborts the partial byte without a strobe). Data rising while the clock is high is a stop and returns the slave to idle with the line released.
- R3: The first byte after a start is seven code bits followed by a direction bit (1 = read, 0 = write). Only code 1010000 is acknowledged. Any other code gets no acknowledge for that byte or any later byte until the next start, and causes no strobe.
- R4: For each accepted received byte, the slave pulls the data line low for the whole high phase of the ninth clock.
- R5: While the busy input is high, the slave acknowledges no byte, including the control byte, and issues no write strobe. A byte refused this way ends participation until the next start.
- R6: In a write, the byte after the control byte loads its low seven bits into the pointer. Each later byte is strobed with the current pointer as address, after which the pointer advances by one.
- R7: The pointer wraps from 7Fh to 00h, both on writes and on sequential reads.
- R8: A read sends the byte at the pointer, most significant bit first, advancing the pointer after each byte. A read with no word-address phase starts at the current pointer, and the slave releases the line during each acknowledge slot.
- R9: When the master does not acknowledge a read byte, the slave keeps the line released until the next start or stop.
- R10: The pull-down enable changes only while the bus clock is low. Each change takes effect exactly DRIVE_DLY system clocks after the clock edge that first sees the bus clock low.
- R11: A stop issues a one-cycle commit pulse only when at least one data byte has been strobed since the last start. A write holding only a word address commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock sample |
| sda_i | input | 1 | Synchronized bus data sample |
| busy_i | input | 1 | Self-timed programming cycle in progress |
| rd_data_i | input | 8 | Memory read port data for rd_addr_o |
| rd_addr_o | output | 7 | Current word pointer, memory read address |
| wr_stb_o | output | 1 | One-cycle strobe of an accepted write data byte |
| wr_addr_o | output | 7 | Address belonging to the strobed byte |
| wr_data_o | output | 8 | Strobed write data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the buffered bytes |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The bench acts as a bus master. It runs plain writes, a write that crosses the top address, and a write with only a word address, which separates strobed data from pointer loading and checks when a commit is due. Reads run both from the current pointer and after a repeated start, and they cross the wrap point, which shows whether reads fetch from the pointer and step it in order. Wrong device codes, a busy phase before and during a write, and a start cutting a byte short all must produce silence and no strobes. The timing of every change of the pull-down enable is measured against the last bus clock fall.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } i2cs_st_e;
endpackage

// File: rtl/i2cs_cond.sv
// Bus event detector: clock edges, start and stop from consecutive samples.
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_q & scl_i & sda_q & ~sda_i;
    stop_o  = scl_q & scl_i & ~sda_q & sda_i;
    rise_o  = ~scl_q & scl_i;
    fall_o  = scl_q & ~scl_i;
  end
endmodule

// File: rtl/i2cs_drv_dly.sv
// Holds a requested pull-down value and applies it DLY clocks after the request.
module i2cs_drv_dly #(
  parameter int DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  logic val_i,
  input  logic rel_i,
  output logic oe_o
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);

  logic          oe_q, oe_n;
  logic          pend_q, pend_n;
  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    oe_n   = oe_q;
    pend_n = pend_q;
    act_n  = act_q;
    cnt_n  = cnt_q;
    if (rel_i) begin
      oe_n  = 1'b0;
      act_n = 1'b0;
    end else if (ld_i) begin
      pend_n = val_i;
      cnt_n  = CW'(DLY - 1);
      act_n  = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        oe_n  = pend_q;
        act_n = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      oe_q   <= oe_n;
      pend_q <= pend_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
    end
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/i2cs_ptr.sv
// Word pointer: loadable, increments modulo 2**AW.
module i2cs_ptr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (ld_i)       ptr_n = ld_val_i;
    else if (inc_i) ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         AW        = 7,
  parameter logic [6:0] DEV_CODE  = 7'b1010000,
  parameter int         DRIVE_DLY = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic                          busy_i,
  input  logic [i2cs_pkg::BYTE_W-1:0]   rd_data_i,
  output logic [AW-1:0]                 rd_addr_o,
  output logic                          wr_stb_o,
  output logic [AW-1:0]                 wr_addr_o,
  output logic [i2cs_pkg::BYTE_W-1:0]   wr_data_o,
  output logic                          wr_commit_o,
  output logic                          sda_oe_o
);
  import i2cs_pkg::*;

  localparam int            BITW    = 4;
  localparam logic [BITW-1:0] ACK_POS = BITW'(BYTE_W);
  localparam logic [BITW-1:0] END_POS = BITW'(BYTE_W + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic cond_start, cond_stop, cond_rise, cond_fall;

  i2cs_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (cond_start),
    .stop_o  (cond_stop),
    .rise_o  (cond_rise),
    .fall_o  (cond_fall)
  );

  logic          ptr_ld, ptr_inc;
  logic [AW-1:0] ptr;

  i2cs_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ld_i     (ptr_ld),
    .ld_val_i (shf_ld_val),
    .inc_i    (ptr_inc),
    .ptr_o    (ptr)
  );

  logic drv_ld, drv_val, drv_rel;

  i2cs_drv_dly #(.DLY(DRIVE_DLY)) u_drv (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ld_i  (drv_ld),
    .val_i (drv_val),
    .rel_i (drv_rel),
    .oe_o  (sda_oe_o)
  );

  // byte engine state
  i2cs_st_e            st_q, st_n;
  logic [BITW-1:0]     bit_q, bit_n;
  logic [BYTE_W-1:0]   shf_q, shf_n;
  logic                mack_q, mack_n;
  logic                rdf_q, rdf_n;
  logic                wrote_q, wrote_n;
  logic                stb_q, stb_n;
  logic [AW-1:0]       sadr_q, sadr_n;
  logic [BYTE_W-1:0]   sdat_q, sdat_n;
  logic                cmt_q, cmt_n;
  logic [AW-1:0]       shf_ld_val;

  assign shf_ld_val = shf_q[AW-1:0];

  always_comb begin
    st_n    = st_q;
    bit_n   = bit_q;
    shf_n   = shf_q;
    mack_n  = mack_q;
    rdf_n   = rdf_q;
    wrote_n = wrote_q;
    stb_n   = 1'b0;
    sadr_n  = sadr_q;
    sdat_n  = sdat_q;
    cmt_n   = 1'b0;
    drv_ld  = 1'b0;
    drv_val = 1'b0;
    drv_rel = 1'b0;
    ptr_ld  = 1'b0;
    ptr_inc = 1'b0;

    if (cond_stop) begin
      st_n    = ST_IDLE;
      bit_n   = '0;
      drv_rel = 1'b1;
      cmt_n   = wrote_q;
      wrote_n = 1'b0;
    end else if (cond_start) begin
      st_n    = ST_CTRL;
      bit_n   = '0;
      drv_rel = 1'b1;
      wrote_n = 1'b0;
      rdf_n   = 1'b0;
    end else if (st_q != ST_IDLE && st_q != ST_SKIP) begin
      if (cond_rise) begin
        if (bit_q < ACK_POS) begin
          if (st_q != ST_RDATA) shf_n = {shf_q[BYTE_W-2:0], sda_i};
          bit_n = bit_q + 1'b1;
        end else if (bit_q == ACK_POS) begin
          mack_n = ~sda_i;
          bit_n  = END_POS;
        end
      end else if (cond_fall) begin
        if (bit_q == ACK_POS) begin
          // byte complete: decide what happens in the ninth clock
          drv_ld = 1'b1;
          unique case (st_q)
            ST_CTRL: begin
              if (shf_q[BYTE_W-1:1] == DEV_CODE && !busy_i) begin
                drv_val = 1'b1;
                if (shf_q[0]) begin
                  st_n  = ST_RDATA;
                  rdf_n = 1'b1;
                end else begin
                  st_n  = ST_ADDR;
                end
              end else begin
                st_n = ST_SKIP;
              end
            end
            ST_ADDR: begin
              if (!busy_i) begin
                drv_val = 1'b1;
                ptr_ld  = 1'b1;
                st_n    = ST_WDATA;
              end else begin
                st_n = ST_SKIP;
              end
            end
            ST_WDATA: begin
              if (!busy_i) begin
                drv_val = 1'b1;
                stb_n   = 1'b1;
                sadr_n  = ptr;
                sdat_n  = shf_q;
                ptr_inc = 1'b1;
                wrote_n = 1'b1;
              end else begin
                st_n = ST_SKIP;
              end
            end
            ST_RDATA: begin
              drv_val = 1'b0;
              ptr_inc = 1'b1;
            end
            default: drv_val = 1'b0;
          endcase
        end else if (bit_q == END_POS) begin
          // end of ninth clock
          bit_n  = '0;
          drv_ld = 1'b1;
          if (st_q == ST_RDATA) begin
            if (rdf_q || mack_q) begin
              shf_n   = rd_data_i;
              drv_val = ~rd_data_i[BYTE_W-1];
              rdf_n   = 1'b0;
            end else begin
              st_n    = ST_SKIP;
              drv_val = 1'b0;
            end
          end else begin
            drv_val = 1'b0;
          end
        end else if (bit_q != '0 && st_q == ST_RDATA) begin
          drv_ld  = 1'b1;
          drv_val = ~shf_q[BYTE_W-2];
          shf_n   = {shf_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      shf_q   <= '0;
      mack_q  <= 1'b0;
      rdf_q   <= 1'b0;
      wrote_q <= 1'b0;
      stb_q   <= 1'b0;
      sadr_q  <= '0;
      sdat_q  <= '0;
      cmt_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      bit_q   <= bit_n;
      shf_q   <= shf_n;
      mack_q  <= mack_n;
      rdf_q   <= rdf_n;
      wrote_q <= wrote_n;
      stb_q   <= stb_n;
      sadr_q  <= sadr_n;
      sdat_q  <= sdat_n;
      cmt_q   <= cmt_n;
    end
  end

  assign rd_addr_o   = ptr;
  assign wr_stb_o    = stb_q;
  assign wr_addr_o   = sadr_q;
  assign wr_data_o   = sdat_q;
  assign wr_commit_o = cmt_q;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int AW = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               busy_i,
  input logic               sda_oe_o,
  input logic               wr_stb_o,
  input logic [AW-1:0]      wr_addr_o,
  input logic [AW-1:0]      rd_addr_o,
  input logic               wr_commit_o,
  input logic               sda_i,
  input logic               start_w,
  input logic               stop_w,
  input i2cs_pkg::i2cs_st_e state_w
);
  // R10: pull-down enable holds while the bus clock stays high
  assert_oe_quiet_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_w) && !$past(stop_w)) |-> $stable(sda_oe_o));

  // R5: a strobed byte was accepted while busy was low
  assert_no_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !$past(busy_i));

  // R11: commit follows a stop seen on the bus
  assert_commit_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> ($past(scl_i) && $past(sda_i) && !$past(sda_i, 2)));

  // R6/R7: pointer already stepped (modulo) when a byte is strobed
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (rd_addr_o == wr_addr_o + AW'(1)));

  // R11: strobe and commit never coincide
  assert_stb_cmt_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && wr_commit_o));

  // R2: idle slave never pulls the line
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == i2cs_pkg::ST_IDLE) |-> !sda_oe_o);
endmodule

bind i2c_mem_slave i2cs_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .busy_i      (busy_i),
  .sda_oe_o    (sda_oe_o),
  .wr_stb_o    (wr_stb_o),
  .wr_addr_o   (wr_addr_o),
  .rd_addr_o   (rd_addr_o),
  .wr_commit_o (wr_commit_o),
  .sda_i       (sda_i),
  .start_w     (cond_start),
  .stop_w      (cond_stop),
  .state_w     (st_q)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int AW  = 7;
  localparam int DLY = 3;
  localparam int H   = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       busy = 1'b0;
  logic       sda_bus;
  logic [7:0] rd_data;
  logic [6:0] rd_addr;
  logic       wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       wr_commit;
  logic       sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int commit_cnt = 0;
  int cyc = 0;
  logic scl_prev = 1'b1;
  logic oe_last = 1'b0;
  logic done = 1'b0;
  logic [14:0] exp_q[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [6:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  assign rd_data = memf(rd_addr);
  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_slave #(.AW(AW), .DEV_CODE(7'b1010000), .DRIVE_DLY(DLY)) i_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .busy_i(busy),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit),
    .sda_oe_o(sda_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycles since the edge that first saw the bus clock low
  always @(posedge clk) begin
    scl_prev <= scl;
    if (scl_prev && !scl) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // monitor: scoreboard for write strobes, commit count, drive timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected strobe", {wr_addr, wr_data}, 0);
        end else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R6 strobe addr/data", {wr_addr, wr_data}, e);
        end
      end
      if (wr_commit) commit_cnt++;
      if (sda_oe != oe_last) begin
        if (scl) chk(1'b0, "R10 enable changed with clock high", 1, 0);
        else chk(cyc == DLY, "R10 drive delay", cyc, DLY);
      end
      oe_last = sda_oe;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl = 1'b1;   wt(H);
    sda_m = 1'b0; wt(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl = 1'b1;   wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(H);
      scl = 1'b1;   wt(H);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    send_bits(b, 8);
    sda_m = 1'b1; wt(H);
    scl = 1'b1;   wt(1);
    a1 = ~sda_bus; wt(H - 2);
    a2 = ~sda_bus; wt(1);
    scl = 1'b0;
    ack = a1 & a2;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(H);
      scl = 1'b1;   wt(H / 2);
      b[i] = sda_bus; wt(H - H / 2);
      scl = 1'b0;
    end
    sda_m = ~mack; wt(H);
    scl = 1'b1;    wt(H);
    scl = 1'b0;
  endtask

  task automatic wr_expect(input logic [6:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    int         c0;

    wt(3);
    chk(sda_oe == 1'b0, "R1 enable after reset", sda_oe, 0);
    chk(wr_stb == 1'b0, "R1 strobe after reset", wr_stb, 0);
    chk(wr_commit == 1'b0, "R1 commit after reset", wr_commit, 0);
    rst_n = 1'b1;
    wt(5);
    chk(rd_addr == 7'h00, "R1 pointer after reset", rd_addr, 0);

    // R3 R4 R6 R11: write two bytes at 10h
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R3 R4 control ack", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R4 address ack", ack, 1);
    wr_expect(7'h10, 8'h5A);
    send_byte(8'h5A, ack); chk(ack, "R4 data ack", ack, 1);
    wr_expect(7'h11, 8'hC3);
    send_byte(8'hC3, ack); chk(ack, "R4 data ack", ack, 1);
    c0 = commit_cnt;
    bus_stop();
    chk(commit_cnt == c0 + 1, "R11 commit after data", commit_cnt, c0 + 1);

    // R7: write crosses the top address
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h7F, ack);
    wr_expect(7'h7F, 8'h11);
    send_byte(8'h11, ack);
    wr_expect(7'h00, 8'h22);
    send_byte(8'h22, ack); chk(ack, "R7 ack after wrap", ack, 1);
    bus_stop();
    chk(rd_addr == 7'h01, "R7 pointer after wrap", rd_addr, 1);

    // R6 R11: address only, no commit
    c0 = commit_cnt;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h05, ack);
    bus_stop();
    chk(commit_cnt == c0, "R11 no commit without data", commit_cnt, c0);
    chk(rd_addr == 7'h05, "R6 pointer load", rd_addr, 5);

    // R8 R9: read from current pointer
    bus_start();
    send_byte(8'hA1, ack); chk(ack, "R8 read control ack", ack, 1);
    recv_byte(1'b1, b); chk(b == memf(7'h05), "R8 current read byte0", b, memf(7'h05));
    recv_byte(1'b0, b); chk(b == memf(7'h06), "R8 current read byte1", b, memf(7'h06));
    wt(H);
    chk(sda_oe == 1'b0, "R9 released after master nack", sda_oe, 0);
    bus_stop();
    chk(rd_addr == 7'h07, "R8 pointer after read", rd_addr, 7);

    // R2 R7 R8: random read through repeated start, crossing wrap
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h7E, ack);
    bus_start();
    send_byte(8'hA1, ack); chk(ack, "R2 ack after repeated start", ack, 1);
    recv_byte(1'b1, b); chk(b == memf(7'h7E), "R8 read 7E", b, memf(7'h7E));
    recv_byte(1'b1, b); chk(b == memf(7'h7F), "R7 read 7F", b, memf(7'h7F));
    recv_byte(1'b0, b); chk(b == memf(7'h00), "R7 read wrapped 00", b, memf(7'h00));
    bus_stop();

    // R3: foreign codes are ignored
    c0 = commit_cnt;
    bus_start();
    send_byte(8'hA2, ack); chk(!ack, "R3 code 1010001 ignored", ack, 0);
    send_byte(8'h33, ack); chk(!ack, "R3 later byte ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hE0, ack); chk(!ack, "R3 code 1110000 ignored", ack, 0);
    send_byte(8'h44, ack); chk(!ack, "R3 later byte ignored", ack, 0);
    bus_stop();
    chk(commit_cnt == c0, "R3 no commit", commit_cnt, c0);

    // R5: busy before and during a write
    busy = 1'b1;
    bus_start();
    send_byte(8'hA0, ack); chk(!ack, "R5 control byte silent", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h40, ack); chk(ack, "R5 address ack while idle", ack, 1);
    busy = 1'b1;
    send_byte(8'h99, ack); chk(!ack, "R5 data silent while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    chk(commit_cnt == c0, "R5 no commit", commit_cnt, c0);
    chk(rd_addr == 7'h40, "R5 pointer not advanced", rd_addr, 'h40);

    // R2: start in the middle of a data byte aborts it
    c0 = commit_cnt;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    send_bits(8'hA5, 3);
    bus_start();
    send_byte(8'hA0, ack); chk(ack, "R2 restart control ack", ack, 1);
    send_byte(8'h30, ack);
    wr_expect(7'h30, 8'h77);
    send_byte(8'h77, ack);
    bus_stop();
    chk(commit_cnt == c0 + 1, "R2 single commit", commit_cnt, c0 + 1);
    chk(sda_oe == 1'b0, "R2 idle after stop", sda_oe, 0);

    wt(4);
    chk(exp_q.size() == 0, "R6 all strobes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule